// File: doc/BRIEF.md
# Unsigned Complex Multiplier

This block multiplies two complex numbers whose four parts are unsigned integers of `W` bits each. The first operand is `x_re + j*x_im`, the second is `y_re + j*y_im`. The block builds four real products: x_re*y_re, x_im*y_im, x_im*y_re and x_re*y_im. It then forms the real part as x_re*y_re minus x_im*y_im, and the imaginary part as x_im*y_re plus x_re*y_im.

Each real product comes from a column-wise multiplier. For every output column it adds the single-bit partial products that fall on that column, plus the carry passed on from the column below. A parameter chooses the output stage. The stage is either purely combinational, or a register that captures a new result on a rising clock edge when the input is flagged valid. The real part is a two's-complement value, and a separate flag reports when it is negative.

Top module: `ucmplx_mult`

## Requirements
- R1: `re_out` is the 2W+1-bit two's-complement value of x_re*y_re − x_im*y_im. All four parts are read as unsigned.
- R2: `im_out` is the 2W+1-bit unsigned value of x_im*y_re + x_re*y_im. It does not wrap, even when every part is all ones.
- R3: `re_neg` is 1 exactly when x_im*y_im is larger than x_re*y_re. It equals bit 2W of `re_out`.
- R4: With W=4 and operands (13 + j9) and (10 + j7), the result is re_out = 67 and im_out = 181.
- R5: In registered mode (STAGE_REG), a result is captured on a rising edge where `in_valid` is 1. It appears on the outputs after that edge, one cycle of latency.
- R6: In registered mode, on a rising edge where `in_valid` is 0, `re_out`, `im_out` and `re_neg` keep their previous values, whatever the operands are.
- R7: In registered mode, `out_valid` equals the `in_valid` sampled at the previous rising edge. In combinational mode it equals `in_valid` directly.
- R8: In registered mode, while `rst_n` is 0, all outputs are 0.
- R9: A part with its top bit set is a large positive magnitude. With all four parts equal to 2^W−1, re_out is 0 and im_out is 2·(2^W−1)^2.
- R10: In combinational mode (STAGE_COMB), the outputs follow the operands with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registered stage |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands on this cycle are meaningful |
| x_re | input | W | Real part of the first operand |
| x_im | input | W | Imaginary part of the first operand |
| y_re | input | W | Real part of the second operand |
| y_im | input | W | Imaginary part of the second operand |
| re_out | output | 2W+1 | Real part, two's complement |
| im_out | output | 2W+1 | Imaginary part, unsigned |
| re_neg | output | 1 | Real part is negative |
| out_valid | output | 1 | Outputs carry a result |

## Verification
The bench builds two copies of the block. The first uses W=4 in registered mode. That is small enough to sweep every one of the 65536 operand combinations, so every carry pattern of the column adder and every sign case of the real part is reached. The sweep also turns `in_valid` off on some cycles, which exercises hold and valid timing. The second copy uses W=16 in combinational mode and takes random operands plus all-ones and zero corners, which reaches the widest column sums and the 33-bit results.

// File: rtl/ucm_pkg.sv
package ucm_pkg;
  typedef enum logic {
    STAGE_COMB = 1'b0,
    STAGE_REG  = 1'b1
  } ucm_stage_e;
endpackage

// File: rtl/ucm_xmul.sv
// Column-wise vertical-and-crosswise unsigned multiplier.
module ucm_xmul #(
  parameter int W = 8
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] prod
);
  localparam int NCOL = 2*W - 1;
  localparam int CW   = $clog2(2*W) + 1;

  logic [CW-1:0] acc;
  logic [CW-1:0] carry;

  always_comb begin
    carry = '0;
    acc   = '0;
    prod  = '0;
    for (int k = 0; k < NCOL; k++) begin
      acc = carry;
      for (int i = 0; i < W; i++) begin
        if ((k - i) >= 0 && (k - i) < W)
          acc = acc + CW'(a[i] & b[k-i]);
      end
      prod[k] = acc[0];
      carry   = acc >> 1;
    end
    prod[2*W-1] = carry[0];
  end
endmodule

// File: rtl/ucm_core.sv
// Four crosswise products combined into real and imaginary parts.
module ucm_core #(
  parameter int W = 8
) (
  input  logic [W-1:0]   x_re,
  input  logic [W-1:0]   x_im,
  input  logic [W-1:0]   y_re,
  input  logic [W-1:0]   y_im,
  output logic [2*W-1:0] p_rr,
  output logic [2*W-1:0] p_ii,
  output logic [2*W-1:0] p_ir,
  output logic [2*W-1:0] p_ri,
  output logic [2*W:0]   re_val,
  output logic [2*W:0]   im_val
);
  localparam int PW = 2*W;
  localparam int RW = 2*W + 1;

  function automatic logic [RW-1:0] diff_part(input logic [PW-1:0] p, input logic [PW-1:0] q);
    return {1'b0, p} - {1'b0, q};
  endfunction

  function automatic logic [RW-1:0] sum_part(input logic [PW-1:0] p, input logic [PW-1:0] q);
    return {1'b0, p} + {1'b0, q};
  endfunction

  ucm_xmul #(.W(W)) u_rr (.a(x_re), .b(y_re), .prod(p_rr));
  ucm_xmul #(.W(W)) u_ii (.a(x_im), .b(y_im), .prod(p_ii));
  ucm_xmul #(.W(W)) u_ir (.a(x_im), .b(y_re), .prod(p_ir));
  ucm_xmul #(.W(W)) u_ri (.a(x_re), .b(y_im), .prod(p_ri));

  assign re_val = diff_part(p_rr, p_ii);
  assign im_val = sum_part(p_ir, p_ri);
endmodule

// File: rtl/ucmplx_mult.sv
module ucmplx_mult #(
  parameter int W = 8,
  parameter ucm_pkg::ucm_stage_e STAGE = ucm_pkg::STAGE_REG
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [W-1:0]   x_re,
  input  logic [W-1:0]   x_im,
  input  logic [W-1:0]   y_re,
  input  logic [W-1:0]   y_im,
  output logic [2*W:0]   re_out,
  output logic [2*W:0]   im_out,
  output logic           re_neg,
  output logic           out_valid
);
  localparam int PW = 2*W;
  localparam int RW = 2*W + 1;

  logic [PW-1:0] p_rr, p_ii, p_ir, p_ri;
  logic [RW-1:0] re_comb, im_comb;
  logic          neg_comb;

  ucm_core #(.W(W)) u_core (
    .x_re(x_re), .x_im(x_im), .y_re(y_re), .y_im(y_im),
    .p_rr(p_rr), .p_ii(p_ii), .p_ir(p_ir), .p_ri(p_ri),
    .re_val(re_comb), .im_val(im_comb)
  );

  assign neg_comb = re_comb[RW-1];

  generate
    if (STAGE == ucm_pkg::STAGE_REG) begin : g_reg
      logic [RW-1:0] re_q, im_q;
      logic          neg_q, vld_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          re_q  <= '0;
          im_q  <= '0;
          neg_q <= 1'b0;
          vld_q <= 1'b0;
        end else begin
          vld_q <= in_valid;
          if (in_valid) begin
            re_q  <= re_comb;
            im_q  <= im_comb;
            neg_q <= neg_comb;
          end
        end
      end

      assign re_out    = re_q;
      assign im_out    = im_q;
      assign re_neg    = neg_q;
      assign out_valid = vld_q;

      AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R7
      AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R7
      AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(re_out) && $stable(im_out) && $stable(re_neg))); // R6
      AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (re_out == $past(re_comb) && im_out == $past(im_comb))); // R5
    end else begin : g_comb
      assign re_out    = re_comb;
      assign im_out    = im_comb;
      assign re_neg    = neg_comb;
      assign out_valid = in_valid;
    end
  endgenerate

  AST_PROD_RR: assert property (@(posedge clk) disable iff (!rst_n)
    p_rr == PW'(x_re * y_re)); // R1
  AST_RE_BALANCE: assert property (@(posedge clk) disable iff (!rst_n)
    RW'(re_comb + {1'b0, p_ii}) == {1'b0, p_rr}); // R1
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (im_comb >= {1'b0, p_ir}) && (im_comb >= {1'b0, p_ri})); // R2
  AST_SIGN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    neg_comb == (p_ii > p_rr)); // R3
endmodule

// File: tb/sim_ucmplx_mult.sv
module sim_ucmplx_mult;
  localparam int CLK_PERIOD = 10;
  localparam int WA = 4;
  localparam int WB = 16;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // registered copy, W=4
  logic            a_vld = 1'b0;
  logic [WA-1:0]   a_xr = '0, a_xi = '0, a_yr = '0, a_yi = '0;
  logic [2*WA:0]   a_re, a_im;
  logic            a_neg, a_ov;

  // combinational copy, W=16
  logic            b_vld = 1'b0;
  logic [WB-1:0]   b_xr = '0, b_xi = '0, b_yr = '0, b_yi = '0;
  logic [2*WB:0]   b_re, b_im;
  logic            b_neg, b_ov;

  ucmplx_mult #(.W(WA), .STAGE(ucm_pkg::STAGE_REG)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(a_vld),
    .x_re(a_xr), .x_im(a_xi), .y_re(a_yr), .y_im(a_yi),
    .re_out(a_re), .im_out(a_im), .re_neg(a_neg), .out_valid(a_ov));

  ucmplx_mult #(.W(WB), .STAGE(ucm_pkg::STAGE_COMB)) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(b_vld),
    .x_re(b_xr), .x_im(b_xi), .y_re(b_yr), .y_im(b_yi),
    .re_out(b_re), .im_out(b_im), .re_neg(b_neg), .out_valid(b_ov));

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural cycle model of the registered copy
  longint m_re = 0, m_im = 0;
  bit     m_neg = 0, m_v = 0, m_prev_v = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_re <= 0; m_im <= 0; m_neg <= 0; m_v <= 0;
    end else begin
      m_v <= a_vld;
      if (a_vld) begin
        longint ac, bd;
        ac = longint'(a_xr) * longint'(a_yr);
        bd = longint'(a_xi) * longint'(a_yi);
        m_re  <= ac - bd;
        m_im  <= longint'(a_xi) * longint'(a_yr) + longint'(a_xr) * longint'(a_yi);
        m_neg <= (bd > ac);
      end
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(m_prev_v ? "R1 real" : "R6 hold real", longint'($signed(a_re)), m_re);
      chk(m_prev_v ? "R2 imag" : "R6 hold imag", longint'(a_im), m_im);
      chk("R3 sign", longint'(a_neg), longint'(m_neg));
      chk("R7 valid", longint'(a_ov), longint'(m_v));
    end
    m_prev_v = m_v;
  end

  task automatic comb_check(input logic [WB-1:0] xr, xi, yr, yi);
    longint ac, bd, im;
    b_xr = xr; b_xi = xi; b_yr = yr; b_yi = yi;
    b_vld = 1'b1;
    #1;
    ac = longint'(xr) * longint'(yr);
    bd = longint'(xi) * longint'(yi);
    im = longint'(xi) * longint'(yr) + longint'(xr) * longint'(yi);
    chk("R10 R1 comb real", longint'($signed(b_re)), ac - bd);
    chk("R10 R2 comb imag", longint'(b_im), im);
    chk("R10 R3 comb sign", longint'(b_neg), longint'(bd > ac));
    chk("R7 comb valid", longint'(b_ov), 1);
    b_vld = 1'b0;
    #1;
    chk("R7 comb valid low", longint'(b_ov), 0);
  endtask

  task automatic drive_a(input logic v, input logic [WA-1:0] xr, xi, yr, yi);
    a_vld = v; a_xr = xr; a_xi = xi; a_yr = yr; a_yi = yi;
  endtask

  initial begin
    @(posedge clk);
    @(negedge clk);
    // R8: reset state
    chk("R8 reset re", longint'(a_re), 0);
    chk("R8 reset im", longint'(a_im), 0);
    chk("R8 reset neg", longint'(a_neg), 0);
    chk("R8 reset valid", longint'(a_ov), 0);
    drive_a(1'b1, 4'd5, 4'd5, 4'd5, 4'd5);
    @(negedge clk);
    chk("R8 reset holds re", longint'(a_re), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R4: the worked example
    drive_a(1'b1, 4'd13, 4'd9, 4'd10, 4'd7);
    @(negedge clk);
    chk("R4 example real", longint'($signed(a_re)), 67);
    chk("R4 example imag", longint'(a_im), 181);
    chk("R5 valid after one edge", longint'(a_ov), 1);
    // R9: all ones
    drive_a(1'b1, 4'hF, 4'hF, 4'hF, 4'hF);
    @(negedge clk);
    chk("R9 all ones real", longint'($signed(a_re)), 0);
    chk("R9 all ones imag", longint'(a_im), 450);
    // R3: negative real part
    drive_a(1'b1, 4'd0, 4'd15, 4'd0, 4'd15);
    @(negedge clk);
    chk("R3 negative real", longint'($signed(a_re)), -225);
    chk("R3 negative flag", longint'(a_neg), 1);
    // R6: inputs change with valid low, outputs hold
    drive_a(1'b0, 4'd3, 4'd1, 4'd2, 4'd4);
    @(negedge clk);
    chk("R6 held real", longint'($signed(a_re)), -225);
    chk("R6 held imag", longint'(a_im), 0);
    chk("R7 valid dropped", longint'(a_ov), 0);
    // full sweep with periodic idle cycles
    for (int n = 0; n < 65536; n++) begin
      drive_a((n % 3) != 2, n[3:0], n[7:4], n[11:8], n[15:12]);
      @(negedge clk);
    end
    drive_a(1'b0, '0, '0, '0, '0);
    @(negedge clk);
    // combinational copy, W=16
    comb_check('1, '1, '1, '1);
    comb_check('0, '1, '0, '1);
    comb_check('1, '0, '1, '0);
    comb_check('0, '0, '0, '0);
    comb_check(16'd13, 16'd9, 16'd10, 16'd7);
    for (int n = 0; n < 400; n++) begin
      comb_check(16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom));
      @(negedge clk);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule